// File: doc/BRIEF.md
# Stalled-Rotor Protection Timer

This block watches one rotor-position (tachometer) signal and detects a motor that has stopped or is turning too slowly. A digital leaky integrator stands in for a timing capacitor. On every timebase tick the integrator fills by a fixed step. Each rising or falling edge of the tachometer signal drains it by a larger fixed step, and the level never goes below zero. The drain step is sized so that a tachometer rate of 10 Hz holds the level steady. At any slower rate the level climbs until it reaches the upper threshold. At that point the rotor is declared stalled.

Once a stall has been declared, the integrator becomes a slow sawtooth. While the level falls from the upper threshold to the lower threshold at the slow rate, the drive is held off. While it climbs back up at the fast rate, the drive is enabled. This gives a short retry burst followed by a long rest, with an on-to-off ratio set by the two rates (1:14 by default). The stall flag stays high through the whole sawtooth. It drops only when a tachometer edge arrives while the drive is enabled, which shows that the retry burst turned the rotor. A protection-enable input bypasses the whole mechanism.

Top module: `stall_guard`

## Requirements
- R1: After reset, `drive_en` is 1, `lock_flag` is 0 and the integrator level is 0.
- R2: On each `tick`, the level rises by CHG_STEP (default 14). The tick on which the level reaches HI_LEVEL (default 8400) sets `lock_flag` to 1 and `drive_en` to 0 on that same clock edge. From an empty integrator with no edges, this happens on the 600th tick.
- R3: Each tachometer edge, rising or falling, lowers the level by EDGE_STEP (default 700), clamped at 0. Edges on an empty integrator leave it at 0.
- R4: With an edge every 40 ticks, the block never locks. With an edge every 60 ticks (each edge following its 60 ticks), it locks on the 60th tick of the 55th period.
- R5: While locked, the drive is off while the level falls by OFF_STEP (default 1) per tick from HI_LEVEL to LO_LEVEL (default 2800), which takes 5600 ticks. The drive is then on while the level rises by CHG_STEP per tick back to HI_LEVEL, which takes 400 ticks. The sawtooth repeats.
- R6: `lock_flag` is 1 exactly while the stall state is held. `drive_en` is 0 only during the falling (off) part of that state, and it changes only on a tick.
- R7: A tachometer edge seen while locked with the drive on releases the stall: `lock_flag` goes to 0 and `drive_en` stays 1.
- R8: Tachometer edges seen during the off part of the stall are ignored. The flag, the drive and the remaining off time are unchanged.
- R9: While `prot_en` is 0, `drive_en` is 1 and `lock_flag` is 0 in the same cycle, whatever the tick and edge activity. The level is cleared, so a later stall needs the full 600 ticks again.
- R10: A change on `fg_in` takes effect at the third rising clock edge after it is applied, because of the two synchronizer stages and the edge register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle timebase pulse (nominally 1 kHz) |
| prot_en | input | 1 | 1 enables stall protection, 0 bypasses it |
| fg_in | input | 1 | Asynchronous tachometer signal from the rotor sensor |
| drive_en | output | 1 | 1 allows the motor drive, 0 forces it off |
| lock_flag | output | 1 | 1 while a stall is declared (drives an open-drain pin) |

## Verification
A tick is due to show its effect at the outputs on the same rising edge that samples it, because the outputs decode the registered phase without further delay. The tick task raises the pulse for one cycle and returns at the following falling edge, so every tick-count check reads the result of exactly the ticks applied. A tachometer toggle is due at the third rising edge (R10). The edge task waits three falling edges before returning, and the release scenario samples at the second and third falling edges to see both sides of that boundary. A change on `prot_en` is due in the same cycle at the outputs, and is sampled one time unit after the drive.

// File: rtl/sg_pkg.sv
package sg_pkg;

    typedef enum logic [1:0] {
        PH_RUN = 2'd0,   // rotor considered turning
        PH_ON  = 2'd1,   // stalled, retry burst (level rising)
        PH_OFF = 2'd2    // stalled, rest period (level falling)
    } sg_phase_e;

endpackage

// File: rtl/sg_fg_edge.sv
module sg_fg_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fg_in,
    output logic fg_edge
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_st_t;

    edge_st_t st_q, st_d;
    logic [SYNC_STAGES-1:0] chain_d;

    assign chain_d[0] = fg_in;
    for (genvar gi = 1; gi < SYNC_STAGES; gi++) begin : g_chain
        assign chain_d[gi] = st_q.sync[gi-1];
    end

    always_comb begin
        st_d      = st_q;
        st_d.sync = chain_d;
        st_d.prev = st_q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fg_edge = st_q.sync[SYNC_STAGES-1] ^ st_q.prev;
endmodule

// File: rtl/sg_core.sv
module sg_core
    import sg_pkg::*;
#(
    parameter int CHG_STEP  = 14,
    parameter int OFF_STEP  = 1,
    parameter int EDGE_STEP = 700,
    parameter int LO_LEVEL  = 2800,
    parameter int HI_LEVEL  = 8400
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      fg_edge,
    input  logic      prot_en,
    output sg_phase_e phase
);
    localparam int LVL_W = $clog2(HI_LEVEL + CHG_STEP + 1);

    typedef logic [LVL_W:0]   ext_t;
    typedef logic [LVL_W-1:0] lvl_t;

    localparam ext_t CHG_X  = ext_t'(CHG_STEP);
    localparam ext_t OFF_X  = ext_t'(OFF_STEP);
    localparam ext_t EDGE_X = ext_t'(EDGE_STEP);
    localparam ext_t LO_X   = ext_t'(LO_LEVEL);
    localparam ext_t HI_X   = ext_t'(HI_LEVEL);

    typedef struct packed {
        sg_phase_e phase;
        lvl_t      level;
    } core_st_t;

    core_st_t st_q, st_d;
    ext_t     lvl_x, charged, drained;

    always_comb begin
        lvl_x   = ext_t'(st_q.level);
        charged = tick ? lvl_x + CHG_X : lvl_x;
        if (!fg_edge)            drained = charged;
        else if (charged > EDGE_X) drained = charged - EDGE_X;
        else                     drained = '0;

        st_d = st_q;
        if (!prot_en) begin
            st_d.phase = PH_RUN;
            st_d.level = '0;
        end else begin
            unique case (st_q.phase)
                PH_RUN: begin
                    if (drained >= HI_X) begin
                        st_d.phase = PH_OFF;
                        st_d.level = lvl_t'(HI_X);
                    end else begin
                        st_d.level = lvl_t'(drained);
                    end
                end
                PH_ON: begin
                    if (fg_edge) begin
                        st_d.phase = PH_RUN;
                        st_d.level = (drained >= HI_X) ? lvl_t'(HI_X - ext_t'(1))
                                                       : lvl_t'(drained);
                    end else if (charged >= HI_X) begin
                        st_d.phase = PH_OFF;
                        st_d.level = lvl_t'(HI_X);
                    end else begin
                        st_d.level = lvl_t'(charged);
                    end
                end
                PH_OFF: begin
                    if (tick) begin
                        if (lvl_x <= LO_X + OFF_X) begin
                            st_d.phase = PH_ON;
                            st_d.level = lvl_t'(LO_X);
                        end else begin
                            st_d.level = lvl_t'(lvl_x - OFF_X);
                        end
                    end
                end
                default: begin
                    st_d.phase = PH_RUN;
                    st_d.level = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_RUN, level: '0};
        else        st_q <= st_d;
    end

    assign phase = st_q.phase;
endmodule

// File: rtl/sg_out.sv
module sg_out
    import sg_pkg::*;
(
    input  logic      prot_en,
    input  sg_phase_e phase,
    output logic      drive_en,
    output logic      lock_flag
);
    always_comb begin
        drive_en  = 1'b1;
        lock_flag = 1'b0;
        if (prot_en) begin
            drive_en  = (phase != PH_OFF);
            lock_flag = (phase != PH_RUN);
        end
    end
endmodule

// File: rtl/stall_guard.sv
module stall_guard
    import sg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CHG_STEP    = 14,
    parameter int OFF_STEP    = 1,
    parameter int EDGE_STEP   = 700,
    parameter int LO_LEVEL    = 2800,
    parameter int HI_LEVEL    = 8400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic prot_en,
    input  logic fg_in,
    output logic drive_en,
    output logic lock_flag
);
    logic      fg_edge;
    sg_phase_e phase;

    sg_fg_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .fg_in   (fg_in),
        .fg_edge (fg_edge)
    );

    sg_core #(
        .CHG_STEP  (CHG_STEP),
        .OFF_STEP  (OFF_STEP),
        .EDGE_STEP (EDGE_STEP),
        .LO_LEVEL  (LO_LEVEL),
        .HI_LEVEL  (HI_LEVEL)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .fg_edge (fg_edge),
        .prot_en (prot_en),
        .phase   (phase)
    );

    sg_out u_out (
        .prot_en   (prot_en),
        .phase     (phase),
        .drive_en  (drive_en),
        .lock_flag (lock_flag)
    );
endmodule

// File: rtl/sg_chk.sv
module sg_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic prot_en,
    input logic drive_en,
    input logic lock_flag
);
    AST_BYPASS_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_en |-> (drive_en && !lock_flag)); // R9

    AST_LOCK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lock_flag) && $past(prot_en)) |-> $past(tick)); // R2

    AST_BURST_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(drive_en) && lock_flag && $past(lock_flag) && $past(prot_en)) |-> $past(tick)); // R5

    AST_DRIVE_DROP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(drive_en) && prot_en && $past(prot_en)) |-> ($past(tick) && lock_flag)); // R6

    AST_RELEASE_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lock_flag) && prot_en) |-> $past(drive_en)); // R7
endmodule

bind stall_guard sg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .prot_en   (prot_en),
    .drive_en  (drive_en),
    .lock_flag (lock_flag)
);

// File: tb/stall_guard_bench.sv
module stall_guard_bench;
    localparam int T_CHG  = 14;
    localparam int T_OFF  = 1;
    localparam int T_EDGE = 700;
    localparam int T_LO   = 2800;
    localparam int T_HI   = 8400;
    localparam int FILL_TICKS  = T_HI / T_CHG;                 // 600
    localparam int REST_TICKS  = (T_HI - T_LO) / T_OFF;        // 5600
    localparam int BURST_TICKS = (T_HI - T_LO) / T_CHG;        // 400

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic prot_en = 1'b1;
    logic fg = 1'b0;
    logic drive_en, lock_flag;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    stall_guard #(
        .SYNC_STAGES (2),
        .CHG_STEP    (T_CHG),
        .OFF_STEP    (T_OFF),
        .EDGE_STEP   (T_EDGE),
        .LO_LEVEL    (T_LO),
        .HI_LEVEL    (T_HI)
    ) u_stall_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .prot_en   (prot_en),
        .fg_in     (fg),
        .drive_en  (drive_en),
        .lock_flag (lock_flag)
    );

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic toggle_fg();
        @(negedge clk) fg = ~fg;
        repeat (3) @(negedge clk);
    endtask

    task automatic rearm();
        @(negedge clk) prot_en = 1'b0;
        @(negedge clk) prot_en = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 drive after reset", drive_en, 1'b1);
        chk("R1 lock after reset", lock_flag, 1'b0);
    endtask

    task automatic t_stall_cycle();
        ticks(FILL_TICKS - 1);
        chk("R2 no lock one tick early", lock_flag, 1'b0);
        ticks(1);
        chk("R2 lock at fill", lock_flag, 1'b1);
        chk("R6 drive off at lock", drive_en, 1'b0);
        ticks(2000);
        toggle_fg();
        toggle_fg();
        chk("R8 lock kept on rest edge", lock_flag, 1'b1);
        chk("R8 drive kept off on rest edge", drive_en, 1'b0);
        ticks(REST_TICKS - 2000 - 1);
        chk("R8 rest length unchanged", drive_en, 1'b0);
        ticks(1);
        chk("R5 burst starts after rest", drive_en, 1'b1);
        chk("R6 lock held in burst", lock_flag, 1'b1);
        ticks(BURST_TICKS - 1);
        chk("R5 burst still on", drive_en, 1'b1);
        ticks(1);
        chk("R5 burst ends", drive_en, 1'b0);
        ticks(REST_TICKS);
        chk("R5 second burst", drive_en, 1'b1);
    endtask

    task automatic t_release();
        ticks(100);
        @(negedge clk) fg = ~fg;
        @(negedge clk);
        @(negedge clk);
        chk("R10 not yet released at 2 edges", lock_flag, 1'b1);
        @(negedge clk);
        chk("R7 released at 3 edges", lock_flag, 1'b0);
        chk("R7 drive on after release", drive_en, 1'b1);
    endtask

    task automatic t_disable();
        // level is 2800 + 100*14 - 700 = 3500
        ticks(349);
        chk("R2 no lock before refill", lock_flag, 1'b0);
        ticks(1);
        chk("R2 lock after refill", lock_flag, 1'b1);
        @(negedge clk) prot_en = 1'b0;
        #1;
        chk("R9 drive forced on", drive_en, 1'b1);
        chk("R9 lock cleared", lock_flag, 1'b0);
        ticks(1000);
        chk("R9 still bypassed", lock_flag, 1'b0);
        chk("R9 drive still on", drive_en, 1'b1);
        @(negedge clk) prot_en = 1'b1;
        ticks(FILL_TICKS - 1);
        chk("R9 level cleared", lock_flag, 1'b0);
        ticks(1);
        chk("R9 full fill after enable", lock_flag, 1'b1);
        rearm();
    endtask

    task automatic t_clamp_step();
        for (int i = 0; i < 4; i++) toggle_fg();
        ticks(FILL_TICKS - 1);
        chk("R3 clamp keeps empty", lock_flag, 1'b0);
        ticks(1);
        chk("R3 clamp fill exact", lock_flag, 1'b1);
        rearm();
        ticks(300);
        toggle_fg();
        ticks(349);
        chk("R3 step not too large", lock_flag, 1'b0);
        ticks(1);
        chk("R3 step not too small", lock_flag, 1'b1);
        rearm();
    endtask

    task automatic t_fast();
        int seen = 0;
        for (int p = 0; p < 75; p++) begin
            ticks(40);
            if (lock_flag !== 1'b0) seen++;
            toggle_fg();
        end
        chk("R4 fast rotation never locks", seen == 0, 1'b1);
        rearm();
    endtask

    task automatic t_slow();
        int seen = 0;
        for (int p = 0; p < 54; p++) begin
            ticks(60);
            if (lock_flag !== 1'b0) seen++;
            toggle_fg();
        end
        chk("R4 slow rotation not early", seen == 0, 1'b1);
        ticks(59);
        chk("R4 slow no lock at tick 59", lock_flag, 1'b0);
        ticks(1);
        chk("R4 slow rotation locks", lock_flag, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stall_cycle();
        t_release();
        t_disable();
        t_clamp_step();
        t_fast();
        t_slow();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule